// File: doc/BRIEF.md
# Four-Stream Byte-Interleaved Backplane Multiplexer

This block merges four received DS1 tributaries onto one serial backplane stream. Each 125 µs backplane frame starts with the four tributary framing bits, in tributary order. After them come the 24 timeslot bytes of every tributary, interleaved byte by byte: tributary 0, 1, 2 and 3 for timeslot 0, then the same order for timeslot 1, and so on. Each byte is sent MSB first. The block reads each byte from its tributary through a one-cycle read strobe. The strobe carries the timeslot index and is issued one transmission unit before the byte goes out. The framing bits come in on four separate pins.

A 2-bit format select sets the frame length and the position of the frame sync pulse. Format 00 is the 12.352 MHz backplane, with 772 bits per frame. Formats 01, 10 and 11 are 16.384 MHz backplanes with 1024 bits per frame; the bits after the DS1 payload are filled with ones. In formats 00 and 01 the sync covers the four framing bits. Format 10 spans the last two and first two bits of the frame boundary, and format 11 spans the last bit and the first bit. A polarity input can make the sync active low in formats 10 and 11. The backplane clock runs at twice the bit rate. A bit-clock-enable output marks the first clock cycle of each bit. An inversion input moves the data and sync transitions to the opposite half of the bit.

Top module: `bpmux_top`

## Requirements
- R1: While `rst` is high at a clock edge, `serData` is 1, `bitClkEn` is 0, `frameSync` is at its inactive level and `rdStrobe` is 0.
- R2: Every serial bit lasts two clock cycles. `bitClkEn` is 1 in the first cycle of each bit and 0 in the second. Counting from the first edge after reset release, `bitClkEn` is 1 in cycles 1, 3, 5 and so on.
- R3: Frame bit positions 0..3 carry `fBit[0]`..`fBit[3]`. From position 4 on, byte index b = (pos-4)/8 (b < 96) carries timeslot b/4 of tributary b%4, MSB first.
- R4: With `muxMode` = 00 the frame is 772 bits long. With the other three codes it is 1024 bits long, and positions 772..1023 carry 1.
- R5: In formats 00 and 01 the sync is active during positions 0..3 and inactive elsewhere.
- R6: In format 10 the sync is active during positions 1022, 1023, 0 and 1.
- R7: In format 11 the sync is active during positions 1023 and 0.
- R8: With `syncActLow` = 1 in formats 10 and 11, `frameSync` is 0 when active and 1 when inactive. In formats 00 and 01 `syncActLow` has no effect and the sync is active high.
- R9: With `clkInvert` = 0, the bit at position p first appears in the cycle in which `bitClkEn` is 1. With `clkInvert` = 1, data and sync come one cycle later, so they change only in cycles where `bitClkEn` is 0.
- R10: Byte b is requested once per frame. `rdStrobe` is one-hot on bit b%4 and `rdTs` is b/4. The request comes in the first cycle of the unit before the byte: byte 0 at position 0, byte b+1 at the first cycle of byte b. `rdData` is used only in the strobe cycle, from lane t = bits 8t+7..8t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| muxMode | input | 2 | Backplane format select |
| syncActLow | input | 1 | Active-low sync in formats 10 and 11 |
| clkInvert | input | 1 | Shift data and sync transitions by half a bit |
| fBit | input | 4 | Framing bit of each tributary |
| rdData | input | 32 | Byte lanes returned by the tributaries |
| rdStrobe | output | 4 | Per-tributary byte request |
| rdTs | output | 5 | Timeslot index of the request |
| serData | output | 1 | Serial backplane data |
| bitClkEn | output | 1 | First cycle of each serial bit |
| frameSync | output | 1 | Frame sync pulse |

## Verification
Every combination of format, sync polarity and inversion that the bench uses runs for more than two frames. Each run has its own random framing bits and a random byte pattern that depends on tributary and timeslot. Lane-specific byte values show a wrong interleave order or a wrong bit order. The byte lanes read zero outside their strobe cycle, so a request issued in the wrong cycle or to the wrong tributary corrupts the data. Runs that cross frame boundaries in each format tell apart the two frame lengths and the four sync windows. Runs with `syncActLow` set in formats 00 and 01 show that the polarity input is ignored there.

// File: rtl/bpmux_pkg.sv
package bpmux_pkg;
  localparam int NUM_TRIB     = 4;
  localparam int TS_PER_FRAME = 24;
  localparam int LONG_SLOTS   = 32;
  localparam int BYTE_W       = 8;

  localparam int TRIB_W    = $clog2(NUM_TRIB);
  localparam int TS_W      = $clog2(LONG_SLOTS);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int F_BITS    = NUM_TRIB;
  localparam int NUM_BYTES = NUM_TRIB * TS_PER_FRAME;
  localparam int SHORT_LEN = NUM_TRIB * (TS_PER_FRAME * BYTE_W + 1);
  localparam int LONG_LEN  = NUM_TRIB * LONG_SLOTS * BYTE_W;
  localparam int POS_W     = $clog2(LONG_LEN);

  typedef struct packed {
    logic              fetch;
    logic [TRIB_W-1:0] fetchTrib;
    logic [TS_W-1:0]   fetchTs;
    logic              load;
    logic              phase0;
    logic              selF;
    logic [TRIB_W-1:0] fIdx;
    logic              selByte;
    logic [BIT_W-1:0]  bitSel;
    logic              syncAct;
  } bpStrb_t;
endpackage

// File: rtl/bpmux_ctrl.sv
module bpmux_ctrl
  import bpmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] muxMode,
  output bpStrb_t    strb
);
  logic [POS_W-1:0] pos;
  logic             phase;
  logic [POS_W-1:0] frameLast;
  logic [POS_W-1:0] rel;
  logic [POS_W-1:0] byteIdx;
  logic [POS_W-1:0] fetchIdx;
  logic [BIT_W-1:0] bitInByte;
  logic             inF;
  logic             inByte;
  logic             unitStart;
  logic             unitEnd;

  assign frameLast = (muxMode == 2'b00) ? POS_W'(SHORT_LEN - 1) : POS_W'(LONG_LEN - 1);

  // bit position and half-bit phase counters
  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) pos <= (pos >= frameLast) ? '0 : pos + POS_W'(1);
    end
  end

  always_comb begin
    rel       = pos - POS_W'(F_BITS);
    byteIdx   = rel >> BIT_W;
    bitInByte = rel[BIT_W-1:0];
    inF       = pos < POS_W'(F_BITS);
    inByte    = !inF && (byteIdx < POS_W'(NUM_BYTES));
    fetchIdx  = (pos == '0) ? '0 : byteIdx + POS_W'(1);
    unitStart = !phase && ((pos == '0) || (inByte && bitInByte == '0));
    unitEnd   = phase && ((pos == POS_W'(F_BITS - 1)) ||
                          (inByte && bitInByte == BIT_W'(BYTE_W - 1)));

    strb.fetch     = !rst && unitStart && (fetchIdx < POS_W'(NUM_BYTES));
    strb.fetchTrib = fetchIdx[TRIB_W-1:0];
    strb.fetchTs   = TS_W'(fetchIdx >> TRIB_W);
    strb.load      = !rst && unitEnd &&
                     (inF || (byteIdx + POS_W'(1) < POS_W'(NUM_BYTES)));
    strb.phase0    = !phase;
    strb.selF      = inF;
    strb.fIdx      = pos[TRIB_W-1:0];
    strb.selByte   = inByte;
    strb.bitSel    = BIT_W'(BYTE_W - 1) - bitInByte;

    unique case (muxMode)
      2'b10:   strb.syncAct = (pos < POS_W'(2)) || (pos >= frameLast - POS_W'(1));
      2'b11:   strb.syncAct = (pos == '0) || (pos == frameLast);
      default: strb.syncAct = inF;
    endcase
  end
endmodule

// File: rtl/bpmux_dp.sv
module bpmux_dp
  import bpmux_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  bpStrb_t                    strb,
  input  logic                       clkInvert,
  input  logic [NUM_TRIB-1:0]        fBit,
  input  logic [NUM_TRIB*BYTE_W-1:0] rdData,
  output logic                       serData,
  output logic                       bitClkEn,
  output logic                       syncAct
);
  logic [BYTE_W-1:0] nextByte;
  logic [BYTE_W-1:0] curByte;
  logic              bitVal;
  logic              s1Data, s1Sync;
  logic              s2Data, s2Sync;

  // one-ahead fetch register and the byte being shifted out
  always_ff @(posedge clk) begin
    if (rst) begin
      nextByte <= '1;
      curByte  <= '1;
    end else begin
      if (strb.fetch) nextByte <= rdData[strb.fetchTrib*BYTE_W +: BYTE_W];
      if (strb.load)  curByte  <= nextByte;
    end
  end

  always_comb begin
    if (strb.selF)         bitVal = fBit[strb.fIdx];
    else if (strb.selByte) bitVal = curByte[strb.bitSel];
    else                   bitVal = 1'b1;
  end

  // stage 1 aligns with bitClkEn, stage 2 is the half-bit shifted copy
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Data   <= 1'b1;
      s1Sync   <= 1'b0;
      s2Data   <= 1'b1;
      s2Sync   <= 1'b0;
      bitClkEn <= 1'b0;
    end else begin
      s1Data   <= bitVal;
      s1Sync   <= strb.syncAct;
      s2Data   <= s1Data;
      s2Sync   <= s1Sync;
      bitClkEn <= strb.phase0;
    end
  end

  assign serData = clkInvert ? s2Data : s1Data;
  assign syncAct = clkInvert ? s2Sync : s1Sync;
endmodule

// File: rtl/bpmux_top.sv
module bpmux_top
  import bpmux_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  muxMode,
  input  logic        syncActLow,
  input  logic        clkInvert,
  input  logic [3:0]  fBit,
  input  logic [31:0] rdData,
  output logic [3:0]  rdStrobe,
  output logic [4:0]  rdTs,
  output logic        serData,
  output logic        bitClkEn,
  output logic        frameSync
);
  bpStrb_t strb;
  logic    syncAct;

  bpmux_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .muxMode (muxMode),
    .strb    (strb)
  );

  bpmux_dp dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .clkInvert (clkInvert),
    .fBit      (fBit),
    .rdData    (rdData),
    .serData   (serData),
    .bitClkEn  (bitClkEn),
    .syncAct   (syncAct)
  );

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_strobe
    assign rdStrobe[t] = strb.fetch && (strb.fetchTrib == TRIB_W'(t));
  end

  assign rdTs      = strb.fetchTs;
  assign frameSync = syncAct ^ (syncActLow && muxMode[1]);
endmodule

// File: rtl/bpmux_chk.sv
module bpmux_chk (
  input logic       clk,
  input logic       rst,
  input logic       clkInvert,
  input logic [3:0] rdStrobe,
  input logic [4:0] rdTs,
  input logic       serData,
  input logic       bitClkEn
);
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdStrobe)); // R10

  AST_REQ_TS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe != 4'b0) |-> (rdTs < 5'd24)); // R10

  AST_REQ_AT_BIT_START: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe != 4'b0) |=> bitClkEn); // R10

  AST_CLKEN_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    bitClkEn |=> !bitClkEn); // R2

  AST_EDGE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (!clkInvert && $stable(clkInvert) && (serData != $past(serData))) |-> bitClkEn); // R9

  AST_EDGE_INVERTED: assert property (@(posedge clk) disable iff (rst)
    (clkInvert && $stable(clkInvert) && (serData != $past(serData))) |-> !bitClkEn); // R9
endmodule

bind bpmux_top bpmux_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .clkInvert (clkInvert),
  .rdStrobe  (rdStrobe),
  .rdTs      (rdTs),
  .serData   (serData),
  .bitClkEn  (bitClkEn)
);

// File: tb/bpmux_top_tb_top.sv
`timescale 1ns/1ps
module bpmux_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  muxMode = 2'b00;
  logic        syncActLow = 1'b0;
  logic        clkInvert = 1'b0;
  logic [3:0]  fBit = 4'b0;
  logic [31:0] rdData;
  logic [3:0]  rdStrobe;
  logic [4:0]  rdTs;
  logic        serData, bitClkEn, frameSync;
  int unsigned seed = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bpmux_top dut_i (
    .clk(clk), .rst(rst), .muxMode(muxMode), .syncActLow(syncActLow),
    .clkInvert(clkInvert), .fBit(fBit), .rdData(rdData), .rdStrobe(rdStrobe),
    .rdTs(rdTs), .serData(serData), .bitClkEn(bitClkEn), .frameSync(frameSync)
  );

  function automatic logic [7:0] dbyte(int unsigned sd, int t, int ts);
    return 8'((sd ^ (t * 32'h35)) + ts * 29 + (sd >> 11));
  endfunction

  // tributary model: a lane reads zero unless it is requested
  always_comb begin
    for (int t = 0; t < 4; t++)
      rdData[t*8 +: 8] = rdStrobe[t] ? dbyte(seed, t, int'(rdTs)) : 8'h00;
  end

  function automatic int frameLen(logic [1:0] m);
    return (m == 2'b00) ? 772 : 1024;
  endfunction

  function automatic logic expBit(int p);
    int b;
    if (p < 4) return fBit[p];
    b = (p - 4) / 8;
    if (b >= 96) return 1'b1;
    return dbyte(seed, b % 4, b / 4) >> (7 - ((p - 4) % 8));
  endfunction

  function automatic logic expSyncAct(int p, logic [1:0] m);
    int len = frameLen(m);
    case (m)
      2'b10:   return (p < 2) || (p >= len - 2);
      2'b11:   return (p == 0) || (p == len - 1);
      default: return p < 4;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runPhase(logic [1:0] m, logic pol, logic inv, int ncyc);
    int len;
    int s;
    int p;
    logic eData, eSync;
    string dTag, sTag;
    rst = 1'b1;
    muxMode = m; syncActLow = pol; clkInvert = inv;
    seed = $urandom; fBit = 4'($urandom);
    len = frameLen(m);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(serData == 1'b1, "R1", int'(serData), 1, "serData in reset");
    check(bitClkEn == 1'b0, "R1", int'(bitClkEn), 0, "bitClkEn in reset");
    check(frameSync == (pol && m[1]), "R1", int'(frameSync), int'(pol && m[1]), "sync in reset");
    check(rdStrobe == 4'b0, "R1", int'(rdStrobe), 0, "rdStrobe in reset");
    rst = 1'b0;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk);
      @(negedge clk);
      // R2 bit clock enable
      check(bitClkEn == ((k - 1) % 2 == 0), "R2", int'(bitClkEn), int'((k - 1) % 2 == 0), "bitClkEn");
      s = inv ? k - 2 : k - 1;
      if (s < 0) begin
        eData = 1'b1; eSync = 1'b0; p = -1;
      end else begin
        p = (s / 2) % len;
        eData = expBit(p);
        eSync = expSyncAct(p, m);
      end
      dTag = inv ? "R9" : ((p >= 772) ? "R4" : "R3");
      sTag = inv ? "R9" : (pol ? "R8" : ((m < 2) ? "R5" : ((m == 2) ? "R6" : "R7")));
      check(serData == eData, dTag, int'(serData), int'(eData), $sformatf("serData pos %0d", p));
      eSync = eSync ^ (pol && m[1]);
      check(frameSync == eSync, sTag, int'(frameSync), int'(eSync), $sformatf("frameSync pos %0d", p));
      // R10 request timing at counter state k
      begin
        int cp = (k / 2) % len;
        int b = -1;
        logic [3:0] eStb;
        if (k % 2 == 0) begin
          if (cp == 0) b = 0;
          else if (cp >= 4 && (cp - 4) % 8 == 0 && (cp - 4) / 8 + 1 < 96) b = (cp - 4) / 8 + 1;
        end
        eStb = (b >= 0) ? 4'(1 << (b % 4)) : 4'b0;
        check(rdStrobe == eStb, "R10", int'(rdStrobe), int'(eStb), $sformatf("rdStrobe state %0d", k));
        if (b >= 0)
          check(rdTs == 5'(b / 4), "R10", int'(rdTs), b / 4, "rdTs");
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    runPhase(2'b00, 1'b0, 1'b0, 2 * 2 * 772 + 60);
    runPhase(2'b01, 1'b1, 1'b0, 2 * 2 * 1024 + 60);  // R8 ignored in 01
    runPhase(2'b10, 1'b0, 1'b0, 2 * 2 * 1024 + 60);
    runPhase(2'b10, 1'b1, 1'b1, 2 * 2 * 1024 + 60);
    runPhase(2'b11, 1'b0, 1'b0, 2 * 2 * 1024 + 60);
    runPhase(2'b11, 1'b1, 1'b0, 2 * 2 * 1024 + 60);
    runPhase(2'b00, 1'b1, 1'b1, 2 * 2 * 772 + 60);   // R8 ignored in 00, R9
    runPhase(2'b01, 1'b0, 1'b1, 2 * 2 * 1024 + 60);
    runPhase(2'b11, 1'b1, 1'b1, 2 * 2 * 1024 + 60);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule